// File: doc/BRIEF.md
# Interleaved Memory Bank Controller

This block accepts a stream of read requests on a 26-bit byte address and spreads them over a set of memory banks. Each bank is a behavioural timing model. It returns read data a fixed number of cycles after it takes a request. After that it stays occupied for a longer recovery window, and during that window it cannot take another access. A compile-time choice decides which address bits pick the bank. With the bank select in the low bits, a sequential stream visits a different bank on every request, so the accesses overlap. With the bank select in the high bits, each bank covers one contiguous region of the address space.

The controller finds the bank for each request and checks whether that bank is still recovering. If it is, the controller holds the request with ready low. It never lets a later request overtake a held one. A small queue of in-flight bank tags returns read data in request order, each word marked by a one-cycle valid pulse. Each bank produces a read word built from its own index and the in-bank address, so the returned data shows exactly how the address was split.

Top module: `ilvmem_top`

## Requirements
- R1: With low-order mapping and 16 banks (default), the bank is reqAddr[3:0] and the in-bank address is reqAddr[25:4]. The returned word carries the bank index in bits 31:24 and the in-bank address, zero-extended, in bits 23:0.
- R2: With high-order mapping (HIGH_ORDER=1) and 16 banks, the bank is reqAddr[25:22] and the in-bank address is reqAddr[21:0]. The word layout is the same as in R1.
- R3: With low-order mapping and 8 banks (BANK_W=3), the bank is reqAddr[2:0] and the in-bank address is reqAddr[25:3]. The word layout is the same as in R1.
- R4: rspValid is high in the cycle that follows exactly ACCESS_CYC (4) rising edges after the edge that accepts the request (reqValid and reqReady both high). It is high for one cycle per accepted request.
- R5: A bank accepts no new request within BUSY_CYC (8) edges of its previous accept. A request held on that bank is accepted on exactly the 8th edge.
- R6: Requests to banks that are not recovering are accepted on consecutive edges. A sequential stream in low-order mode runs at one accept per cycle without a break.
- R7: While the addressed bank is recovering, reqReady stays low. The held request stays at the port, and no later request is taken ahead of it.
- R8: Every accepted request yields exactly one response, and responses come back in the order the requests were accepted.
- R9: After reset, with no traffic, reqReady is high and rspValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A read request is present |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqReady | output | 1 | The request is taken on this edge |
| rspValid | output | 1 | One-cycle pulse marking returned data |
| rspData | output | DATA_W | Returned read word |

## Verification
The assertions assume that the tag queue is at least ACCESS_CYC deep, so that a free bank always means ready. They also assume that the request address stays stable while valid is high, so the bank picked in a cycle is the bank that gets accepted. The stimulus changes the address only just after an accepting edge or while valid is low. It drains all traffic before it switches to another instance. It also keeps the default depth of 8 against a latency of 4.

// File: rtl/ilvmem_pkg.sv
package ilvmem_pkg;
  // Widest bank index carried between control and datapath.
  parameter int MaxBankW = 4;

  typedef struct packed {
    logic                load;      // capture read word for loadBank
    logic [MaxBankW-1:0] loadBank;
    logic                emit;      // drive buffered word of emitBank out
    logic [MaxBankW-1:0] emitBank;
  } ctlStrobe_t;
endpackage

// File: rtl/ilvmem_ctrl.sv
module ilvmem_ctrl
  import ilvmem_pkg::*;
#(
  parameter int BANK_W     = 4,
  parameter int ACCESS_CYC = 4,
  parameter int BUSY_CYC   = 8,
  parameter int TAG_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] bankSel,
  output logic              reqReady,
  output ctlStrobe_t        strobe
);
  localparam int NumBanks = 1 << BANK_W;
  localparam int BusyW    = $clog2(BUSY_CYC + 1);
  localparam int AccW     = $clog2(ACCESS_CYC + 1);
  localparam int PtrW     = $clog2(TAG_DEPTH);
  localparam int CntW     = $clog2(TAG_DEPTH + 1);

  logic [BusyW-1:0]  busyCnt [NumBanks];
  logic [AccW-1:0]   accCnt  [NumBanks];
  logic [BANK_W-1:0] tagMem  [TAG_DEPTH];
  logic [PtrW-1:0]   wrPtr, rdPtr;
  logic [CntW-1:0]   tagCount;
  logic [BANK_W-1:0] headBank;
  logic              accept, emit;

  assign reqReady = (busyCnt[bankSel] == '0) && (tagCount != CntW'(TAG_DEPTH));
  assign accept   = reqValid && reqReady;
  assign headBank = tagMem[rdPtr];
  assign emit     = (tagCount != '0) && (accCnt[headBank] == AccW'(1));

  // Per-bank timing: recovery window and access countdown.
  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyCnt[b] <= '0;
        accCnt[b]  <= '0;
      end else if (accept && bankSel == BANK_W'(b)) begin
        busyCnt[b] <= BusyW'(BUSY_CYC - 1);
        accCnt[b]  <= AccW'(ACCESS_CYC);
      end else begin
        if (busyCnt[b] != '0) busyCnt[b] <= busyCnt[b] - 1'b1;
        if (accCnt[b]  != '0) accCnt[b]  <= accCnt[b] - 1'b1;
      end
    end
  end

  // In-flight tag queue holding bank indices in acceptance order.
  always_ff @(posedge clk) begin
    if (accept) tagMem[wrPtr] <= bankSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      tagCount <= '0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (emit)   rdPtr <= rdPtr + 1'b1;
      case ({accept, emit})
        2'b10:   tagCount <= tagCount + 1'b1;
        2'b01:   tagCount <= tagCount - 1'b1;
        default: tagCount <= tagCount;
      endcase
    end
  end

  assign strobe.load     = accept;
  assign strobe.loadBank = MaxBankW'(bankSel);
  assign strobe.emit     = emit;
  assign strobe.emitBank = MaxBankW'(headBank);
endmodule

// File: rtl/ilvmem_dp.sv
module ilvmem_dp
  import ilvmem_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int BANK_W     = 4,
  parameter bit HIGH_ORDER = 1'b0,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctlStrobe_t        strobe,
  output logic [BANK_W-1:0] bankSel,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int InW      = ADDR_W - BANK_W;
  localparam int NumBanks = 1 << BANK_W;

  logic [InW-1:0]    inAddr;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] bankBuf [NumBanks];

  if (HIGH_ORDER) begin : g_high
    assign bankSel = reqAddr[ADDR_W-1 -: BANK_W];
    assign inAddr  = reqAddr[InW-1:0];
  end else begin : g_low
    assign bankSel = reqAddr[BANK_W-1:0];
    assign inAddr  = reqAddr[ADDR_W-1:BANK_W];
  end

  // Behavioural bank contents: bank index on top, in-bank address below.
  always_comb begin
    word                = '0;
    word[InW-1:0]       = inAddr;
    word[DATA_W-1 -: 8] = 8'(bankSel);
  end

  always_ff @(posedge clk) begin
    if (strobe.load) bankBuf[strobe.loadBank[BANK_W-1:0]] <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.emit;
      if (strobe.emit) rspData <= bankBuf[strobe.emitBank[BANK_W-1:0]];
    end
  end
endmodule

// File: rtl/ilvmem_top.sv
module ilvmem_top
  import ilvmem_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int BANK_W     = 4,
  parameter bit HIGH_ORDER = 1'b0,
  parameter int DATA_W     = 32,
  parameter int ACCESS_CYC = 4,
  parameter int BUSY_CYC   = 8,
  parameter int TAG_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [BANK_W-1:0] bankSel;
  ctlStrobe_t        strobe;

  ilvmem_ctrl #(
    .BANK_W(BANK_W), .ACCESS_CYC(ACCESS_CYC),
    .BUSY_CYC(BUSY_CYC), .TAG_DEPTH(TAG_DEPTH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .bankSel(bankSel),
    .reqReady(reqReady), .strobe(strobe)
  );

  ilvmem_dp #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .HIGH_ORDER(HIGH_ORDER), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .strobe(strobe),
    .bankSel(bankSel), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/ilvmem_chk.sv
module ilvmem_chk #(
  parameter int ADDR_W     = 26,
  parameter int BANK_W     = 4,
  parameter bit HIGH_ORDER = 1'b0,
  parameter int DATA_W     = 32,
  parameter int ACCESS_CYC = 4,
  parameter int BUSY_CYC   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData
);
  localparam int NumBanks = 1 << BANK_W;
  localparam int HoldW    = $clog2(BUSY_CYC + 1);

  logic [BANK_W-1:0] bank;
  logic              accept;
  logic [HoldW-1:0]  holdCnt   [NumBanks];
  logic [ACCESS_CYC:0] accPipe;
  logic [BANK_W-1:0] bankPipe  [ACCESS_CYC+1];

  if (HIGH_ORDER) begin : g_high
    assign bank = reqAddr[ADDR_W-1 -: BANK_W];
  end else begin : g_low
    assign bank = reqAddr[BANK_W-1:0];
  end
  assign accept = reqValid && reqReady;

  for (genvar b = 0; b < NumBanks; b++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) holdCnt[b] <= '0;
      else if (accept && bank == BANK_W'(b)) holdCnt[b] <= HoldW'(BUSY_CYC - 1);
      else if (holdCnt[b] != '0) holdCnt[b] <= holdCnt[b] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accPipe <= '0;
      for (int i = 0; i <= ACCESS_CYC; i++) bankPipe[i] <= '0;
    end else begin
      accPipe     <= {accPipe[ACCESS_CYC-1:0], accept};
      bankPipe[0] <= bank;
      for (int i = 1; i <= ACCESS_CYC; i++) bankPipe[i] <= bankPipe[i-1];
    end
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == accPipe[ACCESS_CYC]); // R4
  AST_BANK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> holdCnt[bank] == '0); // R5
  AST_FREE_BANK_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && holdCnt[bank] == '0) |-> reqReady); // R6
  AST_RSP_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspData[DATA_W-1 -: 8] == 8'(bankPipe[ACCESS_CYC])); // R8
  AST_RSP_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !$isunknown(rspData)); // R8
endmodule

bind ilvmem_top ilvmem_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .HIGH_ORDER(HIGH_ORDER),
  .DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC), .BUSY_CYC(BUSY_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData)
);

// File: tb/ilvmem_top_tb_top.sv
module ilvmem_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  reqValid = '0;
  logic [25:0] reqAddr = '0;
  logic [2:0]  reqReady, rspValid;
  logic [31:0] rspData [3];

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [31:0] expData [3][64];
  int          expCyc  [3][64];
  int          qHead [3] = '{0, 0, 0};
  int          qTail [3] = '{0, 0, 0};

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // instance 0: low-order 16 banks; 1: high-order 16 banks; 2: low-order 8 banks
  ilvmem_top #(.BANK_W(4), .HIGH_ORDER(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqAddr(reqAddr),
    .reqReady(reqReady[0]), .rspValid(rspValid[0]), .rspData(rspData[0]));
  ilvmem_top #(.BANK_W(4), .HIGH_ORDER(1'b1)) dutHi_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqAddr(reqAddr),
    .reqReady(reqReady[1]), .rspValid(rspValid[1]), .rspData(rspData[1]));
  ilvmem_top #(.BANK_W(3), .HIGH_ORDER(1'b0)) dut8_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[2]), .reqAddr(reqAddr),
    .reqReady(reqReady[2]), .rspValid(rspValid[2]), .rspData(rspData[2]));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int cfg, input logic [25:0] a);
    logic [31:0] w = '0;
    case (cfg)
      0: begin w[31:24] = 8'(a[3:0]);   w[21:0] = a[25:4]; end  // R1
      1: begin w[31:24] = 8'(a[25:22]); w[21:0] = a[21:0]; end  // R2
      default: begin w[31:24] = 8'(a[2:0]); w[22:0] = a[25:3]; end  // R3
    endcase
    return w;
  endfunction

  function automatic string mapTag(input int cfg);
    return (cfg == 0) ? "R1" : (cfg == 1) ? "R2" : "R3";
  endfunction

  // Monitor: record accepts, compare responses (data per mapping, timing R4, order R8).
  always @(negedge clk) begin
    if (rstN) begin
      for (int k = 0; k < 3; k++) begin
        if (reqValid[k] && reqReady[k]) begin
          expData[k][qTail[k] % 64] = expWord(k, reqAddr);
          expCyc[k][qTail[k] % 64]  = cyc + 5;
          qTail[k]++;
        end
        if (rspValid[k]) begin
          if (qHead[k] == qTail[k]) begin
            check(1'b0, "R8 unexpected response", rspData[k], 32'h0);
          end else begin
            check(rspData[k] == expData[k][qHead[k] % 64], mapTag(k),
                  rspData[k], expData[k][qHead[k] % 64]);
            check(cyc == expCyc[k][qHead[k] % 64], "R4 latency",
                  32'(cyc), 32'(expCyc[k][qHead[k] % 64]));
            qHead[k]++;
          end
        end
      end
    end
  end

  // Issue one request; returns at #1 after the accepting edge.
  task automatic issue(input int k, input logic [25:0] a, output int accCyc,
                       output int stalls);
    reqValid   = '0;
    reqValid[k] = 1'b1;
    reqAddr    = a;
    stalls     = 0;
    accCyc     = -1;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (reqReady[k]) begin
        accCyc = cyc;
        @(posedge clk); #1;
        break;
      end
      stalls++;
      @(posedge clk); #1;
    end
    if (accCyc < 0) check(1'b0, "R7 request never accepted", 32'(stalls), 32'd0);
  endtask

  task automatic drain(input int k);
    reqValid = '0;
    repeat (16) @(posedge clk);
    #1;
    check(qHead[k] == qTail[k], "R8 all responses returned",
          32'(qTail[k] - qHead[k]), 32'd0);
  endtask

  // {cfg[1:0], addr[25:0], expected accept gap[3:0]}; gap 0 = not checked
  localparam logic [31:0] VEC [17] = '{
    {2'd0, 26'h0000000, 4'd0}, {2'd0, 26'h0000001, 4'd1},
    {2'd0, 26'h0000002, 4'd1}, {2'd0, 26'h0000012, 4'd8},
    {2'd0, 26'h3FFFFFF, 4'd1}, {2'd0, 26'h3FFFFF3, 4'd1},
    {2'd0, 26'h000000F, 4'd7},
    {2'd1, 26'h0000000, 4'd0}, {2'd1, 26'h0400000, 4'd1},
    {2'd1, 26'h0000004, 4'd7}, {2'd1, 26'h3C00001, 4'd1},
    {2'd1, 26'h2ABCDEF, 4'd1},
    {2'd2, 26'h0000000, 4'd0}, {2'd2, 26'h0000008, 4'd8},
    {2'd2, 26'h0000009, 4'd1}, {2'd2, 26'h0000017, 4'd1},
    {2'd2, 26'h0000011, 4'd7}
  };

  initial begin
    int acc, prevAcc, stalls, prevCfg;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(reqReady[k] == 1'b1, "R9 ready after reset", 32'(reqReady[k]), 32'd1);
      check(rspValid[k] == 1'b0, "R9 no response after reset", 32'(rspValid[k]), 32'd0);
    end
    @(posedge clk); #1;

    prevCfg = -1;
    prevAcc = 0;
    for (int i = 0; i < 17; i++) begin
      int cfg = int'(VEC[i][31:30]);
      int gap = int'(VEC[i][3:0]);
      if (prevCfg >= 0 && cfg != prevCfg) drain(prevCfg);
      issue(cfg, VEC[i][29:4], acc, stalls);
      if (gap > 1) begin
        check(acc - prevAcc == gap, "R5 bank recovery spacing", 32'(acc - prevAcc), 32'(gap));
        check(stalls == gap - 1, "R7 held while bank busy", 32'(stalls), 32'(gap - 1));
      end else if (gap == 1) begin
        check(acc - prevAcc == 1, "R6 back-to-back accept", 32'(acc - prevAcc), 32'd1);
      end
      prevAcc = acc;
      prevCfg = cfg;
    end
    drain(2);

    // R6: sustained sequential low-order stream, 32 requests in 32 cycles.
    issue(0, 26'h0000100, prevAcc, stalls);
    for (int i = 1; i < 32; i++) begin
      issue(0, 26'h0000100 + 26'(i), acc, stalls);
      check(acc - prevAcc == 1, "R6 sequential stream overlap", 32'(acc - prevAcc), 32'd1);
      prevAcc = acc;
    end
    drain(0);

    // R8: idle port produces no responses (monitor flags any stray pulse).
    repeat (10) @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++)
      check(qHead[k] == qTail[k], "R8 queue empty at end", 32'(qTail[k] - qHead[k]), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired (R8) actual=%0d expected=<20000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule